// File: doc/BRIEF.md
# Legacy I/O Transaction Port Router

This block sits on the outbound I/O path and works out where each I/O-cycle request goes. A request carries a byte address in a 64 KB I/O space plus one extra wrap bit. The router sends it to one of four PCI Express ports (IDs 1 to 4) or to the default legacy port (ID 0). It also reports whether the address hit one of the special decodes. Each port owns a contiguous run of 4 KB segments, set by a segment base and a segment limit written through a simple write port. A per-port VGA enable picks the owner of the VGA register ranges.

Requests enter with a valid/ready handshake. The decision is registered and presented with the same kind of handshake one cycle after acceptance. The router does not forward the transaction itself: it returns the destination port ID, a decode kind and the 16-bit address to forward.

Top module: `io_port_router`

## Requirements
- R1: While and after a synchronous reset, `rsp_valid` is 0 and `req_ready` is 1. Every port window starts disabled, so every non-special access goes to port 0 until windows are programmed.
- R2: `req_ready` is high when `rsp_valid` is low or `rsp_ready` is high. A request accepted on a clock edge appears on `rsp_*` right after that edge. The response stays unchanged while `rsp_valid` is high and `rsp_ready` is low. Back-to-back requests are accepted one per cycle.
- R3: Address bit 16 has no effect on the decode, and `rsp_addr` equals bits 15:0 of the request. An access just past 64 KB therefore decodes as the matching address from 0000h.
- R4: Port p (1 to 4) matches when base_p ≤ addr[15:12] ≤ limit_p. If several ports match, the lowest-numbered port wins. `rsp_port` never exceeds 4.
- R5: A port whose limit is below its base matches no address.
- R6: A non-special access in segment 0 (0000h–0FFFh) goes to port 0 whatever the windows say.
- R7: Addresses 0CF8h–0CFBh give kind 1 (configuration address) and 0CFCh–0CFFh give kind 2 (configuration data). Both go to port 0 and take precedence over every other decode.
- R8: Addresses 03B0h–03BBh and 03C0h–03DFh give kind 3 (VGA) and take precedence over the windows. If exactly one port has its VGA enable set, the access goes to that port. With none set or more than one set, it goes to port 0.
- R9: A non-special access that matches no window goes to port 0 with kind 0.
- R10: A configuration write in the same cycle that a request is accepted does not affect that request; it affects only later requests.
- R11: A configuration write whose port index is 0 or above 4 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | 17 | Byte address; bit 16 is the wrap bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 3 | Port index written (1 to 4) |
| cfg_base | input | 4 | First segment owned by the port |
| cfg_limit | input | 4 | Last segment owned by the port |
| cfg_vga | input | 1 | VGA enable for the port |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_port | output | 3 | Destination: 0 legacy, 1 to 4 PCI Express |
| rsp_kind | output | 2 | 0 plain, 1 config address, 2 config data, 3 VGA |
| rsp_addr | output | 16 | Address to forward, wrap bit removed |

## Verification
The hardest case to reach is a configuration write landing in the same cycle as a request acceptance. The bench forces it with a task that raises both strobes together while the output path is free. It expects the old mapping for that request and the new mapping for the next one. Overlapping windows, a disabled port, and zero, one or two VGA owners are set up in turn. Each setup is probed with addresses next to the range edges and with wrapped addresses. The consumer's ready signal stalls in a repeating pattern so that held responses are seen under backpressure.

// File: rtl/io_rt_pkg.sv
`timescale 1ns/1ps
package io_rt_pkg;

  typedef enum logic [1:0] {
    K_PLAIN    = 2'd0,
    K_CFG_ADDR = 2'd1,
    K_CFG_DATA = 2'd2,
    K_VGA      = 2'd3
  } io_kind_e;

  localparam logic [15:0] CFG_ADDR_BASE = 16'h0CF8;
  localparam logic [15:0] CFG_DATA_BASE = 16'h0CFC;
  localparam logic [15:0] VGA_MONO_LO   = 16'h03B0;
  localparam logic [15:0] VGA_MONO_HI   = 16'h03BB;
  localparam logic [15:0] VGA_COLOR_LO  = 16'h03C0;
  localparam logic [15:0] VGA_COLOR_HI  = 16'h03DF;

endpackage

// File: rtl/io_rt_regs.sv
`timescale 1ns/1ps
module io_rt_regs #(
  parameter int NUM_PORTS = 4,
  parameter int SEG_W     = 4,
  parameter int PORT_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [PORT_W-1:0]               cfg_port,
  input  logic [SEG_W-1:0]                cfg_base,
  input  logic [SEG_W-1:0]                cfg_limit,
  input  logic                            cfg_vga,
  output logic [NUM_PORTS-1:0][SEG_W-1:0] base_q,
  output logic [NUM_PORTS-1:0][SEG_W-1:0] lim_q,
  output logic [NUM_PORTS-1:0]            vga_q
);

  // One register set per downstream port; reset leaves the window empty
  // (limit below base) and the VGA enable off.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic sel;
    assign sel = cfg_we && (cfg_port == PORT_W'(g + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '1;
        lim_q[g]  <= '0;
        vga_q[g]  <= 1'b0;
      end else if (sel) begin
        base_q[g] <= cfg_base;
        lim_q[g]  <= cfg_limit;
        vga_q[g]  <= cfg_vga;
      end
    end
  end

  // R11: a write aimed at a non-existent index leaves every register alone
  assert_bad_index_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && ((cfg_port == '0) || (cfg_port > PORT_W'(NUM_PORTS))))
      |=> ($stable(base_q) && $stable(lim_q) && $stable(vga_q)));

endmodule

// File: rtl/io_rt_window.sv
`timescale 1ns/1ps
module io_rt_window #(
  parameter int NUM_PORTS = 4,
  parameter int SEG_W     = 4,
  parameter int PORT_W    = 3
) (
  input  logic [SEG_W-1:0]                seg,
  input  logic [NUM_PORTS-1:0][SEG_W-1:0] base_q,
  input  logic [NUM_PORTS-1:0][SEG_W-1:0] lim_q,
  output logic                            hit,
  output logic [PORT_W-1:0]               hit_port
);

  logic [NUM_PORTS-1:0] match;

  // A window with limit below base can never satisfy both compares.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_cmp
    assign match[g] = (seg >= base_q[g]) && (seg <= lim_q[g]);
  end

  // Lowest-numbered matching port wins: scan downward so it is written last.
  always_comb begin
    hit_port = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (match[i]) hit_port = PORT_W'(i + 1);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/io_rt_special.sv
`timescale 1ns/1ps
module io_rt_special
  import io_rt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_PORTS-1:0] vga_en,
  output logic                 is_special,
  output io_kind_e             sp_kind,
  output logic [PORT_W-1:0]    sp_port
);

  logic                 is_cfg_a;
  logic                 is_cfg_d;
  logic                 is_vga;
  logic                 vga_excl;
  logic [PORT_W-1:0]    vga_owner;
  logic [PORT_W:0]      vga_cnt;
  logic [ADDR_W-1:0]    dword;

  assign dword    = {addr[ADDR_W-1:2], 2'b00};
  assign is_cfg_a = (dword == ADDR_W'(CFG_ADDR_BASE));
  assign is_cfg_d = (dword == ADDR_W'(CFG_DATA_BASE));
  assign is_vga   = ((addr >= ADDR_W'(VGA_MONO_LO))  && (addr <= ADDR_W'(VGA_MONO_HI))) ||
                    ((addr >= ADDR_W'(VGA_COLOR_LO)) && (addr <= ADDR_W'(VGA_COLOR_HI)));

  always_comb begin
    vga_cnt   = '0;
    vga_owner = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (vga_en[i]) begin
        vga_cnt   = vga_cnt + 1'b1;
        vga_owner = PORT_W'(i + 1);
      end
    end
  end

  assign vga_excl = (vga_cnt == (PORT_W+1)'(1));

  // Configuration ports outrank the VGA ranges.
  always_comb begin
    is_special = 1'b1;
    sp_kind    = K_PLAIN;
    sp_port    = '0;
    if (is_cfg_a) begin
      sp_kind = K_CFG_ADDR;
    end else if (is_cfg_d) begin
      sp_kind = K_CFG_DATA;
    end else if (is_vga) begin
      sp_kind = K_VGA;
      sp_port = vga_excl ? vga_owner : '0;
    end else begin
      is_special = 1'b0;
    end
  end

  // R8: shared or missing VGA ownership falls back to the legacy port
  assert_vga_shared_legacy_R8: assert property (@(posedge clk) disable iff (rst)
    (sp_kind == K_VGA && !$onehot(vga_en)) |-> (sp_port == '0));

  // R8: a single owner always receives VGA traffic on a PCI Express port
  assert_vga_single_owner_R8: assert property (@(posedge clk) disable iff (rst)
    (sp_kind == K_VGA && $onehot(vga_en)) |-> (sp_port != '0));

endmodule

// File: rtl/io_rt_outreg.sv
`timescale 1ns/1ps
module io_rt_outreg #(
  parameter int DATA_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready  = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  // R2: a stalled decision does not move
  assert_hold_stalled_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1: nothing is presented in the cycle right after reset
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

endmodule

// File: rtl/io_port_router.sv
`timescale 1ns/1ps
module io_port_router
  import io_rt_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int ADDR_W    = 16,
  parameter  int SEG_W     = 4,
  localparam int PORT_W    = $clog2(NUM_PORTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              cfg_we,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [SEG_W-1:0]  cfg_base,
  input  logic [SEG_W-1:0]  cfg_limit,
  input  logic              cfg_vga,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PORT_W-1:0] rsp_port,
  output logic [1:0]        rsp_kind,
  output logic [ADDR_W-1:0] rsp_addr
);

  localparam int PAY_W = PORT_W + 2 + ADDR_W;

  logic [NUM_PORTS-1:0][SEG_W-1:0] base_q;
  logic [NUM_PORTS-1:0][SEG_W-1:0] lim_q;
  logic [NUM_PORTS-1:0]            vga_q;

  logic [ADDR_W-1:0] io_addr;
  logic [SEG_W-1:0]  seg;
  logic              win_hit;
  logic [PORT_W-1:0] win_port;
  logic              sp_hit;
  io_kind_e          sp_kind;
  logic [PORT_W-1:0] sp_port;
  logic [PORT_W-1:0] dec_port;
  io_kind_e          dec_kind;
  logic [PAY_W-1:0]  dec_pay;
  logic [PAY_W-1:0]  rsp_pay;

  // The wrap bit is dropped: accesses just past the top fold onto 0000h.
  assign io_addr = req_addr[ADDR_W-1:0];
  assign seg     = io_addr[ADDR_W-1 -: SEG_W];

  io_rt_regs #(.NUM_PORTS(NUM_PORTS), .SEG_W(SEG_W), .PORT_W(PORT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_port  (cfg_port),
    .cfg_base  (cfg_base),
    .cfg_limit (cfg_limit),
    .cfg_vga   (cfg_vga),
    .base_q    (base_q),
    .lim_q     (lim_q),
    .vga_q     (vga_q)
  );

  io_rt_window #(.NUM_PORTS(NUM_PORTS), .SEG_W(SEG_W), .PORT_W(PORT_W)) u_window (
    .seg      (seg),
    .base_q   (base_q),
    .lim_q    (lim_q),
    .hit      (win_hit),
    .hit_port (win_port)
  );

  io_rt_special #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_special (
    .clk        (clk),
    .rst        (rst),
    .addr       (io_addr),
    .vga_en     (vga_q),
    .is_special (sp_hit),
    .sp_kind    (sp_kind),
    .sp_port    (sp_port)
  );

  // Precedence: special decodes, then segment 0, then windows, then default.
  always_comb begin
    dec_kind = K_PLAIN;
    dec_port = '0;
    if (sp_hit) begin
      dec_kind = sp_kind;
      dec_port = sp_port;
    end else if (seg == '0) begin
      dec_port = '0;
    end else if (win_hit) begin
      dec_port = win_port;
    end
  end

  assign dec_pay = {dec_port, dec_kind, io_addr};

  io_rt_outreg #(.DATA_W(PAY_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (dec_pay),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_pay)
  );

  assign rsp_port = rsp_pay[PAY_W-1 -: PORT_W];
  assign rsp_kind = rsp_pay[ADDR_W +: 2];
  assign rsp_addr = rsp_pay[ADDR_W-1:0];

  // R4: destination is always an existing port
  assert_port_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_port <= PORT_W'(NUM_PORTS)));

  // R6: plain traffic in the lowest segment stays on the legacy port
  assert_seg0_legacy_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd0 && rsp_addr[ADDR_W-1 -: SEG_W] == '0) |-> (rsp_port == '0));

  // R7: configuration decodes always target the legacy port
  assert_cfg_legacy_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_kind == 2'd1 || rsp_kind == 2'd2)) |-> (rsp_port == '0));

  // R3: a wrapped request forwards only its low address bits
  assert_wrap_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_addr[ADDR_W]) |=> (rsp_addr == $past(req_addr[ADDR_W-1:0])));

endmodule

// File: tb/test_io_port_router.sv
`timescale 1ns/1ps
module test_io_port_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_port = '0;
  logic [3:0]  cfg_base = '0;
  logic [3:0]  cfg_limit = '0;
  logic        cfg_vga = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_port;
  logic [1:0]  rsp_kind;
  logic [15:0] rsp_addr;

  always #2.5 clk = ~clk;

  io_port_router i_io_port_router (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_vga(cfg_vga),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_port(rsp_port), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr)
  );

  typedef struct packed {
    logic [2:0]  p;
    logic [1:0]  k;
    logic [15:0] a;
  } exp_t;

  exp_t exp_q[$];
  string tag_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit stall = 1'b0;
  bit done  = 1'b0;

  logic [3:0] m_base [1:4];
  logic [3:0] m_lim  [1:4];
  logic       m_vga  [1:4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [16:0] a);
    exp_t e;
    logic [15:0] x;
    int cnt;
    logic [2:0] own;
    x = a[15:0];
    e.a = x; e.p = 3'd0; e.k = 2'd0;
    if (x[15:2] == 14'h033E) e.k = 2'd1;
    else if (x[15:2] == 14'h033F) e.k = 2'd2;
    else if ((x >= 16'h03B0 && x <= 16'h03BB) || (x >= 16'h03C0 && x <= 16'h03DF)) begin
      e.k = 2'd3; cnt = 0; own = 3'd0;
      for (int i = 1; i <= 4; i++) if (m_vga[i]) begin cnt++; own = 3'(i); end
      e.p = (cnt == 1) ? own : 3'd0;
    end else if (x[15:12] != 4'd0) begin
      for (int i = 4; i >= 1; i--)
        if (x[15:12] >= m_base[i] && x[15:12] <= m_lim[i]) e.p = 3'(i);
    end
    return e;
  endfunction

  task automatic send(input logic [16:0] a, input string req);
    req_addr  = a;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    exp_q.push_back(model(a));
    tag_q.push_back(req);
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, "R2", "valid after accept", 32'(rsp_valid), 32'd1);
  endtask

  task automatic wr(input logic [2:0] p, input logic [3:0] b, input logic [3:0] l, input logic v);
    cfg_port = p; cfg_base = b; cfg_limit = l; cfg_vga = v; cfg_we = 1'b1;
    @(posedge clk);
    if (p >= 3'd1 && p <= 3'd4) begin m_base[p] = b; m_lim[p] = l; m_vga[p] = v; end
    #1 cfg_we = 1'b0;
  endtask

  // R10: request acceptance and register write share one edge
  task automatic send_with_write(input logic [16:0] a, input logic [2:0] p,
                                 input logic [3:0] b, input logic [3:0] l, input logic v);
    req_addr = a; req_valid = 1'b1;
    cfg_port = p; cfg_base = b; cfg_limit = l; cfg_vga = v; cfg_we = 1'b1;
    do @(negedge clk); while (!req_ready);
    exp_q.push_back(model(a));
    tag_q.push_back("R10");
    @(posedge clk);
    m_base[p] = b; m_lim[p] = l; m_vga[p] = v;
    #1 req_valid = 1'b0; cfg_we = 1'b0;
  endtask

  // Consumer ready pattern
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      rsp_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    end
  end

  // Monitor: pops expectations on each transfer, checks held responses
  initial begin
    bit   held_v = 1'b0;
    exp_t held;
    exp_t got;
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      got = {rsp_port, rsp_kind, rsp_addr};
      if (!rst) begin
        if (held_v)
          check(rsp_valid === 1'b1 && got === held, "R2", "stalled response held",
                32'(got), 32'(held));
        if (rsp_valid && rsp_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected response", 32'(got), 32'd0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(got === e, t, "port/kind/addr", 32'(got), 32'(e));
          end
        end
        held_v = rsp_valid && !rsp_ready;
        held   = got;
      end
    end
  end

  // Watchdog
  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 1; i <= 4; i++) begin m_base[i] = 4'hF; m_lim[i] = 4'h0; m_vga[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R1", "valid in reset", 32'(rsp_valid), 32'd0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1", "valid after reset", 32'(rsp_valid), 32'd0);
    check(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
    @(posedge clk); #1;

    // R1 / R9: unprogrammed windows route everything to the legacy port
    send(17'h05000, "R1");
    send(17'h0F123, "R1");

    // R4, R5, R9: overlapping and disabled windows
    wr(3'd1, 4'h1, 4'h3, 1'b0);
    wr(3'd2, 4'h4, 4'h7, 1'b0);
    wr(3'd3, 4'h6, 4'hA, 1'b0);
    wr(3'd4, 4'hB, 4'h2, 1'b0);
    send(17'h01000, "R4");
    send(17'h03FFF, "R4");
    send(17'h04000, "R4");
    send(17'h06ABC, "R4");
    send(17'h08000, "R4");
    send(17'h0AFFF, "R4");
    send(17'h0B500, "R5");
    send(17'h0C000, "R9");

    // R6: window that reaches down into segment 0
    wr(3'd1, 4'h0, 4'h1, 1'b0);
    send(17'h00123, "R6");
    send(17'h00FFF, "R6");
    send(17'h01000, "R6");

    // R7: configuration ports, including through wrap
    send(17'h00CF8, "R7");
    send(17'h00CFB, "R7");
    send(17'h00CFC, "R7");
    send(17'h00CFF, "R7");
    send(17'h00CF7, "R7");
    send(17'h10CF8, "R7");

    // R8: VGA ownership cases
    send(17'h003B0, "R8");
    wr(3'd3, 4'h6, 4'hA, 1'b1);
    send(17'h003BB, "R8");
    send(17'h003BC, "R8");
    send(17'h003C0, "R8");
    send(17'h003DF, "R8");
    send(17'h003E0, "R8");
    wr(3'd2, 4'h4, 4'h7, 1'b1);
    send(17'h003D4, "R8");

    // R3: wrap bit ignored
    send(17'h10000, "R3");
    send(17'h10002, "R3");
    send(17'h14000, "R3");

    // R11: writes to index 0 and 5 change nothing
    wr(3'd0, 4'h0, 4'hF, 1'b0);
    wr(3'd5, 4'hC, 4'hF, 1'b1);
    send(17'h0C000, "R11");
    send(17'h003C8, "R11");

    // R10: write and acceptance in the same cycle
    send_with_write(17'h0E000, 3'd1, 4'hE, 4'hF, 1'b0);
    send(17'h0E000, "R10");

    // R2: backpressure with a burst
    stall = 1'b1;
    for (int i = 0; i < 24; i++) send(17'(i * 17'h0B31), "R2");
    stall = 1'b0;

    for (int i = 0; i < 50 && exp_q.size() > 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R2", "responses outstanding", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule